// File: doc/BRIEF.md
# Bidirectional Port Controller with Data-Register Pull-Ups

This block controls a general-purpose I/O port of `PORT_W` pins (eight by default) for a small controller bus. Two registers hold its state: a direction register, where a 1 makes the pin an output, and a data register. A register-bus write loads either register. For every pin the block produces an output enable, a driven level and a pull-up enable. On an input pin the data bit does not drive anything. It turns that pin's pull-up on or off.

A read of the port returns a mix of sources. Input pins give their external level, after a two-flop synchronizer. Output pins give their stored data bit. A small sequencer performs single-bit set and clear operations the way a processor bit instruction does. It reads the whole port, changes one bit and writes all bits back into the data register. Because input bits are read as pin levels, this write-back can change the pull-ups of other input pins. A direct full write of the data register avoids the problem and is the safe path.

Top module: `gpio_port_ctl`

## Requirements
- R1: While and after reset, the direction and data registers are 0. All of `pin_oe`, `pin_out`, `pin_pu` are 0, and `rmw_busy` and `rmw_done` are low.
- R2: A bus write with `wr_en`=1 loads `wr_data` at the next clock edge. The direction register is loaded when `wr_sel`=0 and the data register when `wr_sel`=1. The register that is not selected keeps its value.
- R3: For each bit, `pin_oe` equals the direction bit and `pin_out` equals the data bit.
- R4: For each bit, `pin_pu` is 1 exactly when the direction bit is 0 and the data bit is 1.
- R5: For each bit, `rd_data` returns the synchronized pin level when the direction bit is 0 and the data bit when the direction bit is 1.
- R6: A change on `pin_in` appears on `rd_data` after exactly two rising clock edges, and not after one.
- R7: `rmw_start` is sampled at a clock edge while the sequencer is idle. `rmw_busy` is then high for three cycles. At the third edge after the start edge, the data register takes the result and `rmw_done` pulses high for exactly one cycle.
- R8: The result of a bit operation is the port read value sampled at the first edge after the start. Bit `rmw_idx` of that value is forced to `rmw_set` (1 = set, 0 = clear). All other bits keep the read value, including pin levels of input bits. For example, data 0x80, direction 0x3F and pins 7/6 at low/high, with bit 0 set, gives 0x41.
- R9: `rmw_start` is ignored while `rmw_busy` is high.
- R10: A bus write of the data register in the cycle when the sequencer writes back is discarded. The sequencer result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the direction register, 1 selects the data register |
| wr_data | input | PORT_W | Write value |
| rd_data | output | PORT_W | Port read value |
| pin_in | input | PORT_W | External pin levels, asynchronous |
| pin_oe | output | PORT_W | Per-pin output enable |
| pin_out | output | PORT_W | Per-pin driven level |
| pin_pu | output | PORT_W | Per-pin pull-up enable |
| rmw_start | input | 1 | Start a single-bit operation |
| rmw_idx | input | $clog2(PORT_W) | Bit to modify |
| rmw_set | input | 1 | 1 sets the bit, 0 clears it |
| rmw_busy | output | 1 | Bit operation in progress |
| rmw_done | output | 1 | One-cycle pulse when the result is written |

## Verification
Register writes show on `pin_oe`, `pin_out` and `pin_pu` one edge after the write. A pin change reaches `rd_data` two edges later. A bit operation writes its result and raises `rmw_done` three edges after the start edge. The bench drives inputs on the falling edge and advances its model one edge at a time. It compares every output at the next falling edge, so each result is checked in the exact cycle it is due and in the cycles just before it. The worked pull-up case and writes that collide with the write-back cycle are directed. Everything else comes from seeded random traffic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      RMW_IDLE   = 2'd0,
      RMW_READ   = 2'd1,
      RMW_MODIFY = 2'd2,
      RMW_WRITE  = 2'd3
   } rmw_state_t;

   localparam logic SEL_DIR  = 1'b0;
   localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int PORT_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pin_async,
   output logic [PORT_W-1:0] pin_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [PORT_W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [PORT_W-1:0] wr_data,
   input  logic              rmw_wr,
   input  logic [PORT_W-1:0] rmw_value,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] data_q
);
   import gpio_port_pkg::*;

   logic bus_dir_wr;
   logic bus_data_wr;

   assign bus_dir_wr  = wr_en && (wr_sel == SEL_DIR);
   assign bus_data_wr = wr_en && (wr_sel == SEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dir_q <= '0;
      else if (bus_dir_wr) dir_q <= wr_data;
   end

   // the sequencer write-back has priority over a bus write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           data_q <= '0;
      else if (rmw_wr)      data_q <= rmw_value;
      else if (bus_data_wr) data_q <= wr_data;
   end

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dir_wr |=> dir_q == $past(wr_data));

   assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_wr && !rmw_wr) |=> data_q == $past(wr_data));

   assert_rmw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_wr |=> data_q == $past(rmw_value));
endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq #(
   parameter int PORT_W = 8,
   localparam int IDX_W = $clog2(PORT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  idx,
   input  logic              set_val,
   input  logic [PORT_W-1:0] port_val,
   output logic              rmw_wr,
   output logic [PORT_W-1:0] rmw_value,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  idx_q,
   output logic              set_q
);
   import gpio_port_pkg::*;

   rmw_state_t        state_q;
   logic [PORT_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RMW_IDLE;
         snap_q  <= '0;
         idx_q   <= '0;
         set_q   <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            RMW_IDLE: if (start) begin
               idx_q   <= idx;
               set_q   <= set_val;
               state_q <= RMW_READ;
            end
            RMW_READ: begin
               snap_q  <= port_val;
               state_q <= RMW_MODIFY;
            end
            RMW_MODIFY: begin
               snap_q[idx_q] <= set_q;
               state_q       <= RMW_WRITE;
            end
            RMW_WRITE: begin
               done    <= 1'b1;
               state_q <= RMW_IDLE;
            end
            default: state_q <= RMW_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != RMW_IDLE);
   assign rmw_wr    = (state_q == RMW_WRITE);
   assign rmw_value = snap_q;

   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rmw_wr) |=> ($stable(idx_q) && $stable(set_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int PORT_W = 8
) (
   input  logic [PORT_W-1:0] dir_q,
   input  logic [PORT_W-1:0] data_q,
   input  logic [PORT_W-1:0] pin_sync,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_pu,
   output logic [PORT_W-1:0] port_val
);
   for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      assign pin_oe[b]   = dir_q[b];
      assign pin_out[b]  = data_q[b];
      assign pin_pu[b]   = !dir_q[b] && data_q[b];
      assign port_val[b] = dir_q[b] ? data_q[b] : pin_sync[b];
   end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(PORT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [PORT_W-1:0] wr_data,
   output logic [PORT_W-1:0] rd_data,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_pu,
   input  logic              rmw_start,
   input  logic [IDX_W-1:0]  rmw_idx,
   input  logic              rmw_set,
   output logic              rmw_busy,
   output logic              rmw_done
);
   if (PORT_W < 2 || (1 << IDX_W) != PORT_W) begin : g_bad_width
      $error("gpio_port_ctl: PORT_W must be a power of two of at least 2");
   end

   logic [PORT_W-1:0] dir_q, data_q, pin_sync, port_val, rmw_value;
   logic              rmw_wr, set_q;
   logic [IDX_W-1:0]  idx_q;

   gpio_pin_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync));

   gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rmw_wr(rmw_wr), .rmw_value(rmw_value),
      .dir_q(dir_q), .data_q(data_q));

   gpio_rmw_seq #(.PORT_W(PORT_W)) u_rmw (
      .clk(clk), .rst_n(rst_n), .start(rmw_start), .idx(rmw_idx),
      .set_val(rmw_set), .port_val(port_val), .rmw_wr(rmw_wr),
      .rmw_value(rmw_value), .busy(rmw_busy), .done(rmw_done),
      .idx_q(idx_q), .set_q(set_q));

   gpio_pad_ctl #(.PORT_W(PORT_W)) u_pad (
      .dir_q(dir_q), .data_q(data_q), .pin_sync(pin_sync),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .port_val(port_val));

   assign rd_data = port_val;

   assert_done_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_done |-> pin_out[idx_q] == set_q);

   assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_done |-> !rmw_busy);
endmodule

// File: tb/gpio_port_ctl_bench.sv
module gpio_port_ctl_bench;
   localparam int W = 8;
   localparam int IW = 3;
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_sel = 1'b0;
   logic [W-1:0]  wr_data = '0, pin_in = '0;
   logic [W-1:0]  rd_data, pin_oe, pin_out, pin_pu;
   logic          rmw_start = 1'b0, rmw_set = 1'b0;
   logic [IW-1:0] rmw_idx = '0;
   logic          rmw_busy, rmw_done;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] m_dir = '0, m_data = '0, m_s1 = '0, m_s2 = '0;
   logic         e_busy = 1'b0, e_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctl u_gpio_port_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
      .rmw_start(rmw_start), .rmw_idx(rmw_idx), .rmw_set(rmw_set),
      .rmw_busy(rmw_busy), .rmw_done(rmw_done));

   function automatic logic [W-1:0] f_read(logic [W-1:0] d, logic [W-1:0] v, logic [W-1:0] s);
      return (d & v) | (~d & s);
   endfunction

   function automatic logic [W-1:0] f_pu(logic [W-1:0] d, logic [W-1:0] v);
      return ~d & v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R3 oe", pin_oe, m_dir);
      chk("R3 out", pin_out, m_data);
      chk("R4 pullup", pin_pu, f_pu(m_dir, m_data));
      chk("R5 read", rd_data, f_read(m_dir, m_data, m_s2));
      chk("R7 busy", rmw_busy, e_busy);
      chk("R7 done", rmw_done, e_done);
   endtask

   // one rising edge; bus write applied to the model unless blocked (R10)
   task automatic tick(bit bus_blocked);
      @(posedge clk);
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (wr_en && !bus_blocked) begin
         if (wr_sel) m_data = wr_data;
         else        m_dir  = wr_data;
      end
      @(negedge clk);
      wr_en = 1'b0;
      rmw_start = 1'b0;
      check_all();
   endtask

   task automatic bus_wr(logic sel, logic [W-1:0] v);
      wr_en = 1'b1; wr_sel = sel; wr_data = v;
      tick(1'b0);
   endtask

   // single-bit operation; optional colliding start (R9) and bus write (R10)
   task automatic rmw_op(logic [IW-1:0] idx, logic sv, bit poke_start, bit poke_wr, logic [W-1:0] wv);
      logic [W-1:0] rv;
      rmw_start = 1'b1; rmw_idx = idx; rmw_set = sv;
      e_busy = 1'b1;
      tick(1'b0);                               // start edge
      rv = f_read(m_dir, m_data, m_s2);         // value sampled at next edge
      if (poke_start) begin
         rmw_start = 1'b1; rmw_idx = idx + 1'b1; rmw_set = ~sv;   // R9
      end
      tick(1'b0);                               // read edge
      if (poke_start) begin
         rmw_start = 1'b1; rmw_idx = idx + 2'd2; rmw_set = ~sv;   // R9
      end
      tick(1'b0);                               // modify edge
      if (poke_wr) begin
         wr_en = 1'b1; wr_sel = 1'b1; wr_data = wv;               // R10
      end
      rv[idx] = sv;
      m_data = rv;                              // R8
      e_busy = 1'b0; e_done = 1'b1;
      tick(1'b1);                               // write edge
      e_done = 1'b0;
      tick(1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      // R1: reset state
      @(negedge clk); @(negedge clk);
      check_all();
      rst_n = 1'b1;
      tick(1'b0);

      // R2: only the selected register changes
      bus_wr(1'b1, 8'hA5);
      bus_wr(1'b0, 8'h0F);
      chk("R2 data kept", pin_out, 8'hA5);
      chk("R4 pu mix", pin_pu, 8'hA0);

      // R6: pin change visible after exactly two edges
      pin_in = 8'hF0;
      tick(1'b0);
      chk("R6 one edge", rd_data[7:4], 4'h0);
      tick(1'b0);
      chk("R6 two edges", rd_data[7:4], 4'hF);

      // R8 worked case: bits 7/6 inputs, pin7 low, pin6 high
      bus_wr(1'b0, 8'h3F);
      bus_wr(1'b1, 8'h80);
      pin_in = 8'h40;
      tick(1'b0); tick(1'b0);
      chk("R5 worked read", rd_data, 8'h40);
      chk("R4 worked pu before", pin_pu, 8'h80);
      rmw_op(3'd0, 1'b1, 1'b0, 1'b0, '0);
      chk("R8 worked result", pin_out, 8'h41);
      chk("R8 worked pu after", pin_pu, 8'h40);

      // R9 and R10: colliding start and bus write during the operation
      rmw_op(3'd5, 1'b0, 1'b1, 1'b1, 8'hFF);
      chk("R10 rmw kept", pin_out[7:6] == 2'b01 && pin_out[5] == 1'b0, 1'b1);

      // safe path: full write changes exactly the written bits
      bus_wr(1'b1, 8'h81);
      chk("R2 full write", pin_out, 8'h81);

      // random phase
      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom_range(0, 5);
         pin_in = (op == 0) ? W'($urandom) : pin_in;
         if (op <= 2)      bus_wr(1'($urandom), W'($urandom));
         else if (op == 3) rmw_op(IW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
         else              tick(1'b0);
      end

      // R1: reset returns everything to zero
      rst_n = 1'b0;
      m_dir = '0; m_data = '0; m_s1 = '0; m_s2 = '0;
      @(negedge clk);
      check_all();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule